// File: doc/BRIEF.md
# Battery-Backed Byte-Wide Memory Protection Controller

This block models a nonvolatile byte-wide memory together with the logic that keeps its contents safe. A host drives an active-low chip enable, output enable and write enable, an address and write data. All of these are sampled on the system clock. The block decides whether each access may reach the array.

Supply health arrives as two already-synchronized flags. The first says the supply is high enough to operate. The second says the supply is above the level at which the backup cells take over. Two more flags report whether each backup cell is healthy, and a fifth says which cell is currently the stronger. A manual protect switch turns the memory into read-only storage.

After every power restore, the block checks the cells once. If both are weak, it silently discards the second memory cycle, so software can detect a weak backup with a read, write and read-back test. While the supply is below the switchover level, the block picks a backup cell. If supply and both cells fail together, it flags the contents as lost.

Top module: `nvg_top`

## Requirements
- R1: A read is driven when, at a clock edge, supplyOk=1, ceN=0, oeN=0 and weN=1. After that edge, rdDrive=1 and rdData holds the byte stored at addr.
- R2: A write window spans the consecutive edges at which both ceN and weN are sampled low. The write commits at the first edge after that window where either ceN or weN is sampled high, whichever of them rises first. It stores the wrData and addr sampled at the last edge of the window.
- R3: After any edge where weN is sampled low, rdDrive is 0, even if ceN and oeN are low.
- R4: While supplyOk=0, rdDrive stays 0 with rdData=0, and writes that end in that state leave the array unchanged.
- R5: While protectSw=1, completed writes leave the array unchanged, and reads still return stored data.
- R6: At the first edge where supplyOk is sampled 1 after being 0 (or after reset), the block records whether cellAGood=0 and cellBGood=0. The block counts memory cycles after that edge. A cycle is either a ceN falling edge with weN high, or a completed write. If both cells were weak, the second such cycle has no effect: a read is not driven for as long as ceN stays low, and a write does not commit.
- R7: The cycle count saturates, so the third and later cycles after power-up behave normally. If at least one cell was good at power-up, no cycle is inhibited.
- R8: One edge after supplyAboveSwitch is sampled 0, onBackup=1. One edge after it is sampled 1, onBackup=0.
- R9: While on backup, backupSel (0 = cell A, 1 = cell B) selects the higher cell as given by cellAHigher. If that cell is not good and the other one is, backupSel selects the good one. backupSel holds its value while not on backup.
- R10: batteryWarn is 1 one edge after both cellAGood and cellBGood are sampled 0, and is 0 otherwise.
- R11: If supplyAboveSwitch=0 and both cells are weak at the same edge, dataLost becomes 1 and stays 1 until reset. While dataLost=1, driven reads return 0x00.
- R12: During and directly after reset, rdDrive, rdData, onBackup, backupSel, batteryWarn and dataLost are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address (default 10, 15 for 32K) |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, 0 when not driven |
| rdDrive | output | 1 | Read data bus is being driven |
| supplyOk | input | 1 | Supply above the operating threshold |
| supplyAboveSwitch | input | 1 | Supply above the backup switchover level |
| cellAGood | input | 1 | Backup cell A above its good level |
| cellBGood | input | 1 | Backup cell B above its good level |
| cellAHigher | input | 1 | Cell A reports a higher level than cell B |
| protectSw | input | 1 | Manual write-protect switch |
| onBackup | output | 1 | Backup source selected |
| backupSel | output | 1 | Selected cell, 0 = A, 1 = B |
| batteryWarn | output | 1 | Both cells below their good level |
| dataLost | output | 1 | Sticky flag for lost contents |

## Verification
The hardest situation to reach is the inhibited second cycle. It needs a supplyOk fall and rise while both cell flags are low, and then an exact count of read starts and completed writes. The stimulus repeats the power cycle with a write-first order and with a read-first order, and then checks that the third cycle passes. A further power cycle with one good cell checks that the inhibit does not trigger. Backup selection is driven with supplyOk low and supplyAboveSwitch low, and retention is confirmed by reading the stored data after power returns.

// File: rtl/nvg_pkg.sv
package nvg_pkg;
  typedef struct packed {
    logic latch;
    logic commit;
    logic rdEn;
    logic rdZero;
  } dpCtl_t;
endpackage

// File: rtl/nvg_datapath.sv
module nvg_datapath
  import nvg_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [ADDR_W-1:0] addrHold;
  logic [DATA_W-1:0] dataHold;

  // capture of the write window; the last sampled value wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHold <= '0;
      dataHold <= '0;
    end else if (ctl.latch) begin
      addrHold <= addr;
      dataHold <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.commit) memArr[addrHold] <= dataHold;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDrive <= 1'b0;
      rdData  <= '0;
    end else begin
      rdDrive <= ctl.rdEn;
      rdData  <= (ctl.rdEn && !ctl.rdZero) ? memArr[addr] : '0;
    end
  end

  p_undriven_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.rdEn |=> (rdData == '0));
endmodule

// File: rtl/nvg_ctrl.sv
module nvg_ctrl
  import nvg_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   ceN,
  input  logic   oeN,
  input  logic   weN,
  input  logic   supplyOk,
  input  logic   supplyAboveSwitch,
  input  logic   cellAGood,
  input  logic   cellBGood,
  input  logic   cellAHigher,
  input  logic   protectSw,
  output dpCtl_t dpCtl,
  output logic   onBackup,
  output logic   backupSel,
  output logic   batteryWarn,
  output logic   dataLost
);
  localparam logic [1:0] CNT_SAT = 2'd2;

  logic       ceNQ, okQ, wrActQ, lowAtBoot, rdBlockQ;
  logic [1:0] cycCnt;

  logic writeActive, writeEnd, ceFallRead, powerUp, countEv, isSecond;
  logic bothWeak, selNext;

  assign bothWeak    = !cellAGood && !cellBGood;
  assign writeActive = !ceN && !weN;
  assign writeEnd    = wrActQ && !writeActive;
  assign ceFallRead  = supplyOk && ceNQ && !ceN && weN;
  assign powerUp     = supplyOk && !okQ;
  assign countEv     = ceFallRead || (writeEnd && supplyOk);
  assign isSecond    = lowAtBoot && (cycCnt == 2'd1);

  always_comb begin
    dpCtl.latch  = writeActive;
    dpCtl.commit = writeEnd && supplyOk && !protectSw && !isSecond && !powerUp;
    dpCtl.rdEn   = supplyOk && !ceN && !oeN && weN &&
                   !(rdBlockQ || (ceFallRead && isSecond));
    dpCtl.rdZero = dataLost;
  end

  // bus edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceNQ   <= 1'b1;
      wrActQ <= 1'b0;
      okQ    <= 1'b0;
    end else begin
      ceNQ   <= ceN;
      wrActQ <= writeActive;
      okQ    <= supplyOk;
    end
  end

  // power-up cycle counter and inhibit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt    <= '0;
      lowAtBoot <= 1'b0;
      rdBlockQ  <= 1'b0;
    end else begin
      if (powerUp) begin
        cycCnt    <= '0;
        lowAtBoot <= bothWeak;
      end else if (countEv && cycCnt != CNT_SAT) begin
        cycCnt <= cycCnt + 2'd1;
      end
      if (ceN || powerUp)            rdBlockQ <= 1'b0;
      else if (ceFallRead && isSecond) rdBlockQ <= 1'b1;
    end
  end

  // backup source selection
  assign selNext = (cellAGood && (cellAHigher || !cellBGood)) ? 1'b0 :
                   (cellBGood ? 1'b1 : !cellAHigher);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onBackup    <= 1'b0;
      backupSel   <= 1'b0;
      batteryWarn <= 1'b0;
      dataLost    <= 1'b0;
    end else begin
      onBackup    <= !supplyAboveSwitch;
      batteryWarn <= bothWeak;
      if (!supplyAboveSwitch) backupSel <= selNext;
      if (!supplyAboveSwitch && bothWeak) dataLost <= 1'b1;
    end
  end

  p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cycCnt == CNT_SAT && !powerUp) |=> (cycCnt == CNT_SAT));
  p_backup_on_r8: assert property (@(posedge clk) disable iff (!rstN)
    !supplyAboveSwitch |=> onBackup);
  p_backup_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    supplyAboveSwitch |=> !onBackup);
  p_fallback_a_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!supplyAboveSwitch && cellAGood && !cellBGood) |=> !backupSel);
  p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    supplyAboveSwitch |=> $stable(backupSel));
  p_lost_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    dataLost |=> dataLost);
endmodule

// File: rtl/nvg_top.sv
module nvg_top
  import nvg_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive,
  input  logic              supplyOk,
  input  logic              supplyAboveSwitch,
  input  logic              cellAGood,
  input  logic              cellBGood,
  input  logic              cellAHigher,
  input  logic              protectSw,
  output logic              onBackup,
  output logic              backupSel,
  output logic              batteryWarn,
  output logic              dataLost
);
  dpCtl_t dpCtl;

  nvg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .supplyOk(supplyOk), .supplyAboveSwitch(supplyAboveSwitch),
    .cellAGood(cellAGood), .cellBGood(cellBGood), .cellAHigher(cellAHigher),
    .protectSw(protectSw), .dpCtl(dpCtl), .onBackup(onBackup),
    .backupSel(backupSel), .batteryWarn(batteryWarn), .dataLost(dataLost)
  );

  nvg_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rdDrive(rdDrive)
  );

  p_no_drive_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> !rdDrive);
  p_we_hiz_r3: assert property (@(posedge clk) disable iff (!rstN)
    !weN |=> !rdDrive);
endmodule

// File: tb/nvg_top_tb_top.sv
module nvg_top_tb_top;
  localparam int AW = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic rdDrive;
  logic supplyOk = 1'b1, supplyAboveSwitch = 1'b1;
  logic cellAGood = 1'b1, cellBGood = 1'b1, cellAHigher = 1'b1;
  logic protectSw = 1'b0;
  logic onBackup, backupSel, batteryWarn, dataLost;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    int           due;
    logic         drv;
    logic [DW-1:0] dat;
    string        tag;
  } expItem_t;
  expItem_t scoreQ[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nvg_top #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rdDrive(rdDrive), .supplyOk(supplyOk),
    .supplyAboveSwitch(supplyAboveSwitch), .cellAGood(cellAGood),
    .cellBGood(cellBGood), .cellAHigher(cellAHigher), .protectSw(protectSw),
    .onBackup(onBackup), .backupSel(backupSel), .batteryWarn(batteryWarn),
    .dataLost(dataLost)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    while (scoreQ.size() > 0 && scoreQ[0].due <= cyc) begin
      expItem_t it;
      it = scoreQ.pop_front();
      checks++;
      if (rdDrive !== it.drv || rdData !== it.dat) begin
        errors++;
        $display("FAIL %s: got drive=%0b data=%0h expected drive=%0b data=%0h",
                 it.tag, rdDrive, rdData, it.drv, it.dat);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ceN = 1'b1; oeN = 1'b1; weN = 1'b1;
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit endByCe);
    @(negedge clk);
    addr = a; wrData = d; oeN = 1'b1; ceN = 1'b0; weN = 1'b0;
    @(negedge clk);
    if (endByCe) ceN = 1'b1; else weN = 1'b1;
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] expD,
                    input logic expDrv, input string tag);
    expItem_t it;
    @(negedge clk);
    addr = a; ceN = 1'b0; oeN = 1'b0; weN = 1'b1;
    it.due = cyc + 1; it.drv = expDrv; it.dat = expD; it.tag = tag;
    scoreQ.push_back(it);
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic powerCycle();
    @(negedge clk); supplyOk = 1'b0;
    idle(2);
    @(negedge clk); supplyOk = 1'b1;
    idle(2);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    chk("R12 rdDrive", rdDrive, 0);
    chk("R12 rdData", rdData, 0);
    chk("R12 flags", {onBackup, backupSel, batteryWarn, dataLost}, 0);
    rstN = 1'b1;
    idle(2);
    chk("R12 flags after release", {onBackup, backupSel, batteryWarn, dataLost}, 0);

    // R1 R2 basic write/read, both end orders
    wr(10'd5, 8'hA5, 0);
    rd(10'd5, 8'hA5, 1, "R1 read after write ended by WE");
    wr(10'd6, 8'h3C, 1);
    rd(10'd6, 8'h3C, 1, "R2 write ended by CE");
    rd(10'd5, 8'hA5, 1, "R1 second address");
    idle(2);

    // R3 WE low disables drive
    @(negedge clk); addr = 10'd5; wrData = 8'hA5; ceN = 1'b0; oeN = 1'b0; weN = 1'b0;
    @(negedge clk); chk("R3 no drive with WE low", rdDrive, 0);
    @(negedge clk); chk("R3 still no drive", rdDrive, 0);
    weN = 1'b1; ceN = 1'b1; oeN = 1'b1;
    idle(2);

    // R5 protect switch
    protectSw = 1'b1;
    wr(10'd5, 8'h11, 0);
    rd(10'd5, 8'hA5, 1, "R5 protected write ignored, read works");
    protectSw = 1'b0;
    idle(2);

    // R4 supply not ok
    @(negedge clk); supplyOk = 1'b0;
    rd(10'd6, 8'h00, 0, "R4 read ignored when supply low");
    wr(10'd6, 8'hFF, 0);
    @(negedge clk); supplyOk = 1'b1;
    idle(2);
    rd(10'd6, 8'h3C, 1, "R4 write ignored when supply low");
    idle(2);

    // R6 R10 both cells weak: read first, write second inhibited
    cellAGood = 1'b0; cellBGood = 1'b0;
    powerCycle();
    chk("R10 warning with both cells weak", batteryWarn, 1);
    rd(10'd5, 8'hA5, 1, "R6 first cycle read ok");
    wr(10'd5, 8'h77, 0);
    rd(10'd5, 8'hA5, 1, "R6 second cycle write inhibited");
    wr(10'd5, 8'h77, 0);
    rd(10'd5, 8'h77, 1, "R7 later write commits");

    // R6 write first, read second inhibited
    powerCycle();
    wr(10'd6, 8'h44, 0);
    rd(10'd6, 8'h00, 0, "R6 second cycle read inhibited");
    rd(10'd6, 8'h44, 1, "R7 third cycle read ok");
    idle(2);

    // R7 one good cell: no inhibit
    cellBGood = 1'b1;
    @(negedge clk);
    @(negedge clk); chk("R10 warning clears with one good cell", batteryWarn, 0);
    powerCycle();
    rd(10'd6, 8'h44, 1, "R7 first cycle");
    wr(10'd7, 8'h12, 0);
    rd(10'd7, 8'h12, 1, "R7 second cycle not inhibited with one good cell");
    idle(2);

    // R8 R9 backup selection
    cellAGood = 1'b1; cellBGood = 1'b1; cellAHigher = 1'b1;
    @(negedge clk); supplyOk = 1'b0; supplyAboveSwitch = 1'b0;
    @(negedge clk);
    chk("R8 onBackup set", onBackup, 1);
    chk("R9 selects higher A", backupSel, 0);
    cellAHigher = 1'b0;
    @(negedge clk); chk("R9 selects higher B", backupSel, 1);
    cellBGood = 1'b0;
    @(negedge clk); chk("R9 fallback to good A", backupSel, 0);
    cellBGood = 1'b1; cellAGood = 1'b0; cellAHigher = 1'b1;
    @(negedge clk); chk("R9 fallback to good B", backupSel, 1);
    cellAGood = 1'b1; cellAHigher = 1'b1;
    @(negedge clk); chk("R9 back to A", backupSel, 0);
    supplyAboveSwitch = 1'b1;
    @(negedge clk);
    chk("R8 onBackup released", onBackup, 0);
    cellAHigher = 1'b0;
    @(negedge clk); chk("R9 selection held off backup", backupSel, 0);
    chk("R11 no loss with good cells", dataLost, 0);
    supplyOk = 1'b1;
    idle(2);
    rd(10'd6, 8'h44, 1, "R8 contents retained over backup");
    rd(10'd7, 8'h12, 1, "R8 contents retained over backup 2");
    idle(2);

    // R11 data lost
    @(negedge clk); supplyOk = 1'b0; supplyAboveSwitch = 1'b0;
    cellAGood = 1'b0; cellBGood = 1'b0;
    @(negedge clk); chk("R11 dataLost set", dataLost, 1);
    cellAGood = 1'b1; cellBGood = 1'b1; supplyAboveSwitch = 1'b1;
    @(negedge clk); supplyOk = 1'b1;
    idle(2);
    chk("R11 dataLost sticky", dataLost, 1);
    rd(10'd6, 8'h00, 1, "R11 reads return zero after loss");
    idle(3);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule